// File: doc/BRIEF.md
# Two-Phase Handshake Clock-Domain Link

This block moves one data word at a time from a transmit clock domain to an unrelated receive clock domain. The only wires it adds next to the data bus are a request and an acknowledge. Both are transition-signalled: each new word flips the request level once, and the receiver answers by returning the level it has seen. No return-to-zero phase is needed.

On the transmit side, a one-cycle send strobe hands a word to the block. The block registers the word, flips the request and raises busy. Busy stays high until the returned acknowledge, after two synchronising flops, equals the request level again. The receive side passes the request through two synchronising flops. A third flop remembers the previous synchronised level. Any difference between the two marks a new word, which is captured and presented with a one-cycle valid pulse. The synchronised request level is the acknowledge.

Top module: `hslink_top`

## Requirements
- R1: While its reset is high, and right after it falls, each side is idle: `tx_busy` = 0, `rx_valid` = 0 and `rx_data` = 0.
- R2: A strobe on `tx_send` while `tx_busy` is low is accepted. From the next transmit cycle on, `tx_busy` is 1.
- R3: A strobe on `tx_send` while `tx_busy` is high is ignored. It produces no extra word at the receiver and does not replace the word in flight.
- R4: The word on `tx_data` at the accepting edge is the word delivered. Changes on `tx_data` after acceptance have no effect on it.
- R5: Each accepted word produces exactly one `rx_valid` pulse, one receive cycle wide. `rx_data` equals that word during the pulse, and words arrive in the order they were sent.
- R6: Between valid pulses, `rx_data` keeps the last delivered word.
- R7: `tx_busy` stays high for at least 3 transmit cycles after acceptance. It falls only after the acknowledge has come back, well within 40 transmit cycles for comparable clocks.
- R8: The data width is a parameter, 64 bits by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit domain clock |
| tx_rst | input | 1 | Transmit domain reset, active high, synchronous |
| tx_send | input | 1 | One-cycle strobe offering a word |
| tx_data | input | DATA_W | Word offered with the strobe |
| tx_busy | output | 1 | High while a word is in flight; new strobes are ignored |
| rx_clk | input | 1 | Receive domain clock |
| rx_rst | input | 1 | Receive domain reset, active high, synchronous |
| rx_valid | output | 1 | One-cycle pulse marking a delivered word |
| rx_data | output | DATA_W | Last delivered word |

## Verification
Busy is due one transmit edge after an accepted strobe. The bench samples it at the following falling edge of the transmit clock. The valid pulse is due three to four receive edges after the request flips: two synchroniser flops, the edge comparison, and the output register. Busy falls two transmit edges after the acknowledge flips, plus one more edge. Because the two clocks are unrelated, the bench does not predict exact cycles for the crossing. It checks the due window for busy (at least 3 cycles, under 40) and checks the valid pulse against an ordered scoreboard at every falling receive edge. The two clock periods are chosen so that the falling edges of the two clocks never coincide.

// File: rtl/hslink_pkg.sv
package hslink_pkg;
    localparam int unsigned MIN_SYNC_STAGES = 2;

    function automatic logic level_changed(input logic now_lvl, input logic old_lvl);
        return now_lvl ^ old_lvl;
    endfunction
endpackage

// File: rtl/hslink_sync.sv
module hslink_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hslink_tx.sv
module hslink_tx
    import hslink_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SYNC_N = MIN_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ack_async,
    output logic              req,
    output logic              busy,
    output logic [DATA_W-1:0] data_out
);
    typedef struct packed {
        logic              req;
        logic              busy;
        logic [DATA_W-1:0] word;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      ack_s;
    logic      accept;

    hslink_sync #(.STAGES(SYNC_N)) u_ack_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ack_async),
        .sync_out (ack_s)
    );

    always_comb begin
        st_d   = st_q;
        accept = send && !st_q.busy;
        if (accept) begin
            st_d.req  = !st_q.req;
            st_d.busy = 1'b1;
            st_d.word = data_in;
        end else if (st_q.busy && !level_changed(ack_s, st_q.req)) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req      = st_q.req;
    assign busy     = st_q.busy;
    assign data_out = st_q.word;

    // R2
    accept_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (send && !busy) |=> (busy && (req != $past(req))));

    // R3
    busy_blocks_send_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(req) && $stable(data_out)));

    // R7
    release_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (ack_s == req));

    // R2
    req_moves_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req != $past(req)) |-> busy);
endmodule

// File: rtl/hslink_rx.sv
module hslink_rx
    import hslink_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SYNC_N = MIN_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_async,
    input  logic [DATA_W-1:0] data_async,
    output logic              ack,
    output logic              valid,
    output logic [DATA_W-1:0] data_out
);
    typedef struct packed {
        logic              prev;
        logic              valid;
        logic [DATA_W-1:0] word;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      req_s;
    logic      edge_seen;

    hslink_sync #(.STAGES(SYNC_N)) u_req_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (req_async),
        .sync_out (req_s)
    );

    always_comb begin
        st_d       = st_q;
        edge_seen  = level_changed(req_s, st_q.prev);
        st_d.prev  = req_s;
        st_d.valid = edge_seen;
        if (edge_seen) st_d.word = data_async;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ack      = req_s;
    assign valid    = st_q.valid;
    assign data_out = st_q.word;

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_s == st_q.prev) |=> $stable(data_out));

    // R5
    pulse_follows_level_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (st_q.prev != $past(st_q.prev)));
endmodule

// File: rtl/hslink_top.sv
module hslink_top
    import hslink_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SYNC_N = MIN_SYNC_STAGES
) (
    input  logic              tx_clk,
    input  logic              tx_rst,
    input  logic              tx_send,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_busy,
    input  logic              rx_clk,
    input  logic              rx_rst,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);
    logic              link_req;
    logic              link_ack;
    logic [DATA_W-1:0] link_data;

    hslink_tx #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_tx (
        .clk       (tx_clk),
        .rst       (tx_rst),
        .send      (tx_send),
        .data_in   (tx_data),
        .ack_async (link_ack),
        .req       (link_req),
        .busy      (tx_busy),
        .data_out  (link_data)
    );

    hslink_rx #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_rx (
        .clk        (rx_clk),
        .rst        (rx_rst),
        .req_async  (link_req),
        .data_async (link_data),
        .ack        (link_ack),
        .valid      (rx_valid),
        .data_out   (rx_data)
    );
endmodule

// File: tb/tb_hslink_top.sv
module tb_hslink_top;
    localparam int W = 64;

    logic         tx_clk = 1'b0;
    logic         rx_clk = 1'b0;
    logic         tx_rst, rx_rst;
    logic         tx_send;
    logic [W-1:0] tx_data;
    logic         tx_busy;
    logic         rx_valid;
    logic [W-1:0] rx_data;

    int           n_checks = 0;
    int           n_fail   = 0;
    int           n_sent   = 0;
    int           n_recv   = 0;
    bit           started  = 1'b0;
    bit           done     = 1'b0;
    bit           prev_valid = 1'b0;
    logic [W-1:0] last_word = '0;
    logic [W-1:0] exp_q[$];

    hslink_top #(.DATA_W(W)) dut (
        .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_send(tx_send), .tx_data(tx_data),
        .tx_busy(tx_busy), .rx_clk(rx_clk), .rx_rst(rx_rst),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    always #4 tx_clk = ~tx_clk;
    initial begin
        #1;
        forever #7 rx_clk = ~rx_clk;
    end

    function automatic logic [W-1:0] rand_word();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [W-1:0] walk_word(input int i);
        return {{(W-1){1'b0}}, 1'b1} << (i % W);
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [W-1:0] w, input bit poke, input bit jitter);
        int cyc;
        while (tx_busy) @(negedge tx_clk);
        tx_send = 1'b1;
        tx_data = w;
        exp_q.push_back(w);
        n_sent++;
        @(negedge tx_clk);
        tx_send = 1'b0;
        check(tx_busy == 1'b1, "R2 busy after accept", W'(tx_busy), W'(1));
        if (jitter) tx_data = ~w;
        cyc = 1;
        while (tx_busy && cyc < 60) begin
            tx_send = poke && (cyc == 1);
            if (tx_send) tx_data = rand_word();
            @(negedge tx_clk);
            tx_send = 1'b0;
            cyc++;
        end
        check(cyc >= 3 && cyc <= 40, "R7 busy duration", W'(cyc), W'(3));
    endtask

    always @(negedge rx_clk) begin
        if (started && !rx_rst) begin
            if (rx_valid) begin
                n_recv++;
                check(!prev_valid, "R5 pulse width", W'(prev_valid), W'(0));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected word", rx_data, '0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R5 R4 delivered word", rx_data, e);
                end
                last_word = rx_data;
            end else begin
                check(rx_data == last_word, "R6 data hold", rx_data, last_word);
            end
            prev_valid = rx_valid;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        tx_rst  = 1'b1;
        rx_rst  = 1'b1;
        tx_send = 1'b0;
        tx_data = '0;
        repeat (5) @(negedge tx_clk);
        // R1: idle during reset
        check(tx_busy == 1'b0, "R1 busy in reset", W'(tx_busy), '0);
        check(rx_valid == 1'b0, "R1 valid in reset", W'(rx_valid), '0);
        check(rx_data == '0, "R1 data in reset", rx_data, '0);
        tx_rst = 1'b0;
        rx_rst = 1'b0;
        started = 1'b1;
        @(negedge tx_clk);
        check(tx_busy == 1'b0, "R1 busy after reset", W'(tx_busy), '0);

        // directed corners
        send_word('1, 1'b0, 1'b0);                       // R8 full width ones
        send_word(walk_word(W - 1), 1'b0, 1'b1);         // R4 top bit, port changes
        send_word(64'hA5A5_0F0F_3C3C_9696, 1'b1, 1'b1);  // R3 strobe while busy
        send_word('0, 1'b0, 1'b0);                       // back-to-back, zero word
        for (int i = 0; i < 8; i++) send_word(walk_word(i * 9), 1'b0, 1'b0);

        // random traffic
        for (int i = 0; i < 80; i++) begin
            int gap;
            gap = int'($urandom % 4);
            repeat (gap) @(negedge tx_clk);
            send_word(rand_word(), ($urandom % 3) == 0, ($urandom % 2) == 0);
        end

        repeat (40) @(negedge tx_clk);
        // R3: ignored strobes added no words
        check(n_recv == n_sent, "R3 word count", W'(n_recv), W'(n_sent));
        check(exp_q.size() == 0, "R5 scoreboard drained", W'(exp_q.size()), '0);
        check(tx_busy == 1'b0, "R7 idle at end", W'(tx_busy), '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule